// File: doc/BRIEF.md
# Extended Integer Compare-and-Set Unit

This unit takes two integer operands, compares them under one of eight compare operations, and writes a result word that encodes the outcome. The comparison is signed or unsigned. It runs either as a plain single-word comparison or in a chained mode. In the chained mode it forms `a + ~b + carry_in` and folds in an incoming zero flag. Running this on successive words, starting with the low word, lets values of 64 bits or more be compared across several operations.

The compare outcome is joined with a predicate bit through a selectable boolean operator. The predicate bit may be inverted first. When the joined condition holds, the result word is either all ones or the single-precision encoding of 1.0, chosen by a control bit; otherwise it is zero. On request the unit also produces a new zero-flag value that reflects the result word. It raises an error for combinations it cannot honour.

One request is accepted per cycle with a valid strobe. Results appear one clock later on registered outputs, which hold their value while no request arrives.

Top module: `icmpset_unit`

## Requirements
- R1: `cmp_sel` encodes the operation: 0 never, 1 less-than, 2 equal, 3 less-or-equal, 4 greater-than, 5 not-equal, 6 greater-or-equal, 7 always. Code 0 yields a false compare outcome and code 7 a true one, whatever the operands.
- R2: With `ext_mode` = 0, the unit compares `op_a` against `op_b` as two's-complement values when `is_signed` = 1 and as unsigned values when `is_signed` = 0.
- R3: With `ext_mode` = 1, the unit forms an intermediate value `op_a + ~op_b + carry_in` (modulo 2^WIDTH), with `carry_in` counting as 0 or 1. The ordering tests use the sign bit of this value; "zero" means that the value is all zeros.
- R4: In the chained mode, the base less-than test is the intermediate's sign bit, and the base greater-than test is "sign clear and not zero". When `is_signed` = 0 and the top bits of the operands differ, each base ordering test is replaced by its complement: greater-or-equal, or less-or-equal respectively. When `is_signed` = 1 no replacement takes place.
- R5: In the chained mode, equal is true only when the intermediate is zero and `zero_in` = 1. Not-equal is true when the intermediate is nonzero, or when `zero_in` = 0.
- R6: In the chained mode, less-or-equal and greater-or-equal are their base ordering test ORed with (zero and `zero_in` = 1). Greater-than is its base test ORed with (zero and `zero_in` = 0).
- R7: When `pred_inv` = 1, the predicate bit is inverted before it is combined.
- R8: `bool_sel` chooses how the compare outcome and the predicate combine: 0 AND, 1 OR, 2 XOR.
- R9: When the combined condition is true, the result word is 0xFFFFFFFF if `float_res` = 0 and 0x3F800000 if `float_res` = 1. When the condition is false, the result word is 0.
- R10: When `flag_upd` = 1 and no error is raised, `zf_we` pulses with the result, and `zf_out` is 1 exactly when the result word is zero.
- R11: `err_out` is raised when `flag_upd` and `ext_mode` are both 1, or when `bool_sel` = 3. No flag write is issued with an error. When `bool_sel` = 3, the condition is forced false.
- R12: The outputs register one cycle after the request, and `out_valid` mirrors the previous cycle's `in_valid`. While `in_valid` is low, `out_word` holds its value. A synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| cmp_sel | input | 3 | Compare operation code |
| is_signed | input | 1 | Signed comparison when 1 |
| ext_mode | input | 1 | Chained multiword mode when 1 |
| carry_in | input | 1 | Incoming carry flag for chained mode |
| zero_in | input | 1 | Incoming zero flag for chained mode |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| pred_in | input | 1 | Predicate bit |
| pred_inv | input | 1 | Invert predicate before combining |
| bool_sel | input | 2 | Boolean combine operator |
| float_res | input | 1 | Select 1.0 encoding instead of all ones |
| flag_upd | input | 1 | Request a zero-flag update |
| out_valid | output | 1 | Result valid |
| out_word | output | WIDTH | Result word |
| zf_we | output | 1 | Zero-flag write strobe |
| zf_out | output | 1 | New zero-flag value |
| err_out | output | 1 | Illegal-combination error |

## Verification
The bench builds the unit with its default width of 32, so the operand top bits, the 0x3F800000 constant and the wrap-around of the chained intermediate all appear at their real positions. At this width, operands such as 0x80000005 against 3 bring the unsigned top-bit inversion within reach in both the less-than and the greater-than paths. A carry-in of 0 against equal operands gives an all-ones intermediate, which shows that the carry feeds the sum. The table also reaches every boolean operator, the illegal operator code and both error causes.

// File: rtl/icmpset_pkg.sv
package icmpset_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam logic [31:0] FP_ONE_32 = 32'h3F80_0000;

    typedef enum logic [2:0] {
        CMP_NEVER  = 3'd0,
        CMP_LT     = 3'd1,
        CMP_EQ     = 3'd2,
        CMP_LE     = 3'd3,
        CMP_GT     = 3'd4,
        CMP_NE     = 3'd5,
        CMP_GE     = 3'd6,
        CMP_ALWAYS = 3'd7
    } cmp_op_e;

    typedef enum logic [1:0] {
        BOP_AND = 2'd0,
        BOP_OR  = 2'd1,
        BOP_XOR = 2'd2,
        BOP_BAD = 2'd3
    } bop_e;

    // ordering facts of a plain comparison
    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } order_t;

    // facts derived from the chained intermediate value
    typedef struct packed {
        logic iv_zero;
        logic base_lt;
        logic base_gt;
        logic base_ge;
    } chain_t;

    // outcome of the predicate combine stage
    typedef struct packed {
        logic cond;
        logic err;
        logic flag_wr;
    } comb_t;

    function automatic logic pick_plain(input cmp_op_e op, input order_t o);
        logic r;
        unique case (op)
            CMP_NEVER:  r = 1'b0;
            CMP_LT:     r = o.lt;
            CMP_EQ:     r = o.eq;
            CMP_LE:     r = o.lt | o.eq;
            CMP_GT:     r = o.gt;
            CMP_NE:     r = ~o.eq;
            CMP_GE:     r = o.gt | o.eq;
            CMP_ALWAYS: r = 1'b1;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic pick_chain(input cmp_op_e op, input chain_t c,
                                        input logic zin);
        logic r;
        logic same;
        logic diff;
        same = c.iv_zero & zin;
        diff = c.iv_zero & ~zin;
        unique case (op)
            CMP_NEVER:  r = 1'b0;
            CMP_LT:     r = c.base_lt;
            CMP_EQ:     r = same;
            CMP_LE:     r = c.base_lt | same;
            CMP_GT:     r = c.base_gt | diff;
            CMP_NE:     r = ~c.iv_zero | diff;
            CMP_GE:     r = c.base_ge | same;
            CMP_ALWAYS: r = 1'b1;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic apply_bop(input bop_e b, input logic x, input logic p);
        logic r;
        unique case (b)
            BOP_AND: r = x & p;
            BOP_OR:  r = x | p;
            BOP_XOR: r = x ^ p;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/icmpset_plain_cmp.sv
module icmpset_plain_cmp
    import icmpset_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sgn,
    input  cmp_op_e          op,
    output logic             hit
);
    order_t ord;

    always_comb begin
        ord.eq = (a == b);
        if (sgn) begin
            ord.lt = ($signed(a) < $signed(b));
            ord.gt = ($signed(a) > $signed(b));
        end else begin
            ord.lt = (a < b);
            ord.gt = (a > b);
        end
        hit = pick_plain(op, ord);
    end
endmodule

// File: rtl/icmpset_chain_cmp.sv
module icmpset_chain_cmp
    import icmpset_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sgn,
    input  logic             cin,
    input  logic             zin,
    input  cmp_op_e          op,
    output logic             hit
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] iv;
    logic             flip;
    logic             neg;
    chain_t           cf;

    always_comb begin
        iv   = a + ~b + {{(WIDTH-1){1'b0}}, cin};
        neg  = iv[MSB];
        flip = ~sgn & (a[MSB] ^ b[MSB]);
        cf.iv_zero = (iv == '0);
        // ordering tests on the sign of the intermediate, swapped when flipped
        cf.base_lt = flip ? ~neg : neg;
        cf.base_ge = flip ? neg : ~neg;
        cf.base_gt = flip ? (neg | cf.iv_zero) : (~neg & ~cf.iv_zero);
        hit = pick_chain(op, cf, zin);
    end
endmodule

// File: rtl/icmpset_combine.sv
module icmpset_combine
    import icmpset_pkg::*;
(
    input  logic  cmp_hit,
    input  logic  pred,
    input  logic  pred_neg,
    input  bop_e  bop,
    input  logic  chained,
    input  logic  upd,
    output comb_t res
);
    logic p_eff;
    logic bad_op;

    always_comb begin
        p_eff       = pred ^ pred_neg;
        bad_op      = (bop == BOP_BAD);
        res.err     = bad_op | (upd & chained);
        res.cond    = bad_op ? 1'b0 : apply_bop(bop, cmp_hit, p_eff);
        res.flag_wr = upd & ~res.err;
    end
endmodule

// File: rtl/icmpset_unit.sv
module icmpset_unit
    import icmpset_pkg::*;
#(
    parameter int unsigned     WIDTH  = DATA_W,
    parameter logic [WIDTH-1:0] FP_ONE = FP_ONE_32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       cmp_sel,
    input  logic             is_signed,
    input  logic             ext_mode,
    input  logic             carry_in,
    input  logic             zero_in,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             pred_in,
    input  logic             pred_inv,
    input  logic [1:0]       bool_sel,
    input  logic             float_res,
    input  logic             flag_upd,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_word,
    output logic             zf_we,
    output logic             zf_out,
    output logic             err_out
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    cmp_op_e          op;
    bop_e             bop;
    logic             hit_plain;
    logic             hit_chain;
    logic             hit;
    comb_t            cmb;
    logic [WIDTH-1:0] word_nxt;

    assign op  = cmp_op_e'(cmp_sel);
    assign bop = bop_e'(bool_sel);

    icmpset_plain_cmp #(.WIDTH(WIDTH)) u_plain (
        .a   (op_a),
        .b   (op_b),
        .sgn (is_signed),
        .op  (op),
        .hit (hit_plain)
    );

    icmpset_chain_cmp #(.WIDTH(WIDTH)) u_chain (
        .a   (op_a),
        .b   (op_b),
        .sgn (is_signed),
        .cin (carry_in),
        .zin (zero_in),
        .op  (op),
        .hit (hit_chain)
    );

    assign hit = ext_mode ? hit_chain : hit_plain;

    icmpset_combine u_comb (
        .cmp_hit  (hit),
        .pred     (pred_in),
        .pred_neg (pred_inv),
        .bop      (bop),
        .chained  (ext_mode),
        .upd      (flag_upd),
        .res      (cmb)
    );

    always_comb begin
        if (!cmb.cond)      word_nxt = '0;
        else if (float_res) word_nxt = FP_ONE;
        else                word_nxt = ALL_ONES;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            zf_we     <= 1'b0;
            zf_out    <= 1'b0;
            err_out   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            zf_we     <= in_valid & cmb.flag_wr;
            err_out   <= in_valid & cmb.err;
            if (in_valid) begin
                out_word <= word_nxt;
            end
            if (in_valid && cmb.flag_wr) begin
                zf_out <= (word_nxt == '0);
            end
        end
    end
endmodule

// File: rtl/icmpset_unit_chk.sv
module icmpset_unit_chk #(
    parameter int unsigned      WIDTH  = 32,
    parameter logic [WIDTH-1:0] FP_ONE = 32'h3F80_0000
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       cmp_sel,
    input logic             ext_mode,
    input logic [1:0]       bool_sel,
    input logic             flag_upd,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_word,
    input logic             zf_we,
    input logic             zf_out,
    input logic             err_out
);
    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R12
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R12
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word));
    // R11
    err_noflag_chk: assert property (@(posedge clk) disable iff (rst)
        err_out |-> !zf_we);
    // R11
    ext_flag_err_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && flag_upd && ext_mode) |=> err_out);
    // R11
    bad_bop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bool_sel == 2'd3) |=> (err_out && out_word == '0));
    // R10
    zf_match_chk: assert property (@(posedge clk) disable iff (rst)
        zf_we |-> (zf_out == (out_word == '0)));
    // R1
    never_and_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cmp_sel == 3'd0 && bool_sel == 2'd0) |=> out_word == '0);
    // R9
    word_legal_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word == '0 || out_word == FP_ONE || out_word == {WIDTH{1'b1}}));
endmodule

bind icmpset_unit icmpset_unit_chk #(.WIDTH(WIDTH), .FP_ONE(FP_ONE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .cmp_sel   (cmp_sel),
    .ext_mode  (ext_mode),
    .bool_sel  (bool_sel),
    .flag_upd  (flag_upd),
    .out_valid (out_valid),
    .out_word  (out_word),
    .zf_we     (zf_we),
    .zf_out    (zf_out),
    .err_out   (err_out)
);

// File: tb/icmpset_unit_test.sv
`timescale 1ns/1ps
module icmpset_unit_test;

    typedef struct packed {
        logic [2:0]  cmp;
        logic        sg;
        logic        ext;
        logic        ci;
        logic        zi;
        logic [31:0] a;
        logic [31:0] b;
        logic        pr;
        logic        pi;
        logic [1:0]  bop;
        logic        fl;
        logic        cc;
        logic [31:0] ew;
        logic        ewe;
        logic        ezf;
        logic        eer;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 27;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;
    localparam logic [31:0] F1   = 32'h3F80_0000;

    localparam vec_t TBL [NV] = '{
        // R2 plain unsigned 5 < 7
        '{3'd1,1'b0,1'b0,1'b0,1'b0,32'd5,32'd7,1'b1,1'b0,2'd0,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd2},
        // R2 plain signed -1 < 1
        '{3'd1,1'b1,1'b0,1'b0,1'b0,32'hFFFFFFFF,32'd1,1'b1,1'b0,2'd0,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd2},
        // R2 plain unsigned max < 1 is false
        '{3'd1,1'b0,1'b0,1'b0,1'b0,32'hFFFFFFFF,32'd1,1'b1,1'b0,2'd0,1'b0,1'b0,32'd0,1'b0,1'b0,1'b0,4'd2},
        // R9 equal with float result
        '{3'd2,1'b0,1'b0,1'b0,1'b0,32'h1234,32'h1234,1'b1,1'b0,2'd0,1'b1,1'b0,F1,1'b0,1'b0,1'b0,4'd9},
        // R2 signed min >= 0 is false
        '{3'd6,1'b1,1'b0,1'b0,1'b0,32'h80000000,32'd0,1'b1,1'b0,2'd0,1'b0,1'b0,32'd0,1'b0,1'b0,1'b0,4'd2},
        // R5 chained equal, zero_in set
        '{3'd2,1'b0,1'b1,1'b1,1'b1,32'd10,32'd10,1'b1,1'b0,2'd0,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd5},
        // R5 chained equal, zero_in clear
        '{3'd2,1'b0,1'b1,1'b1,1'b0,32'd10,32'd10,1'b1,1'b0,2'd0,1'b0,1'b0,32'd0,1'b0,1'b0,1'b0,4'd5},
        // R6 chained greater-than via zero and zero_in clear
        '{3'd4,1'b0,1'b1,1'b1,1'b0,32'd10,32'd10,1'b1,1'b0,2'd0,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd6},
        // R3 chained 3 - 5 negative
        '{3'd1,1'b0,1'b1,1'b1,1'b0,32'd3,32'd5,1'b1,1'b0,2'd0,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd3},
        // R4 chained unsigned, top bits differ, less-than inverted
        '{3'd1,1'b0,1'b1,1'b1,1'b0,32'h80000005,32'd3,1'b1,1'b0,2'd0,1'b0,1'b0,32'd0,1'b0,1'b0,1'b0,4'd4},
        // R4 chained signed, no inversion
        '{3'd1,1'b1,1'b1,1'b1,1'b0,32'h80000005,32'd3,1'b1,1'b0,2'd0,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd4},
        // R4 chained unsigned greater-than inverted
        '{3'd4,1'b0,1'b1,1'b1,1'b0,32'h80000005,32'd3,1'b1,1'b0,2'd0,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd4},
        // R5 chained not-equal, zero and zero_in set
        '{3'd5,1'b0,1'b1,1'b1,1'b1,32'd7,32'd7,1'b1,1'b0,2'd0,1'b0,1'b0,32'd0,1'b0,1'b0,1'b0,4'd5},
        // R5 chained not-equal, zero_in clear
        '{3'd5,1'b0,1'b1,1'b1,1'b0,32'd7,32'd7,1'b1,1'b0,2'd0,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd5},
        // R6 chained less-or-equal on equality term
        '{3'd3,1'b0,1'b1,1'b1,1'b1,32'd7,32'd7,1'b1,1'b0,2'd0,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd6},
        // R3 carry 0: intermediate all ones, greater-or-equal false
        '{3'd6,1'b0,1'b1,1'b0,1'b0,32'd7,32'd7,1'b1,1'b0,2'd0,1'b0,1'b0,32'd0,1'b0,1'b0,1'b0,4'd3},
        // R1 never
        '{3'd0,1'b0,1'b0,1'b0,1'b0,32'd1,32'd1,1'b1,1'b0,2'd0,1'b0,1'b0,32'd0,1'b0,1'b0,1'b0,4'd1},
        // R1 always
        '{3'd7,1'b0,1'b0,1'b0,1'b0,32'd1,32'd2,1'b1,1'b0,2'd0,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd1},
        // R8 AND with false predicate
        '{3'd2,1'b0,1'b0,1'b0,1'b0,32'd1,32'd1,1'b0,1'b0,2'd0,1'b0,1'b0,32'd0,1'b0,1'b0,1'b0,4'd8},
        // R8 OR with false predicate
        '{3'd2,1'b0,1'b0,1'b0,1'b0,32'd1,32'd1,1'b0,1'b0,2'd1,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd8},
        // R8 XOR of two trues
        '{3'd2,1'b0,1'b0,1'b0,1'b0,32'd1,32'd1,1'b1,1'b0,2'd2,1'b0,1'b0,32'd0,1'b0,1'b0,1'b0,4'd8},
        // R7 inverted false predicate ANDed
        '{3'd2,1'b0,1'b0,1'b0,1'b0,32'd1,32'd1,1'b0,1'b1,2'd0,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd7},
        // R8 OR: never compare, true predicate
        '{3'd0,1'b0,1'b0,1'b0,1'b0,32'd1,32'd1,1'b1,1'b0,2'd1,1'b0,1'b0,ONES,1'b0,1'b0,1'b0,4'd8},
        // R10 flag update on zero result
        '{3'd2,1'b0,1'b0,1'b0,1'b0,32'd1,32'd2,1'b1,1'b0,2'd0,1'b0,1'b1,32'd0,1'b1,1'b1,1'b0,4'd10},
        // R10 flag update on nonzero float result
        '{3'd7,1'b0,1'b0,1'b0,1'b0,32'd0,32'd0,1'b1,1'b0,2'd0,1'b1,1'b1,F1,1'b1,1'b0,1'b0,4'd10},
        // R11 flag update with chained mode
        '{3'd7,1'b0,1'b1,1'b0,1'b0,32'd0,32'd0,1'b1,1'b0,2'd0,1'b0,1'b1,ONES,1'b0,1'b0,1'b1,4'd11},
        // R11 illegal operator forces false
        '{3'd7,1'b0,1'b0,1'b0,1'b0,32'd0,32'd0,1'b1,1'b0,2'd3,1'b0,1'b0,32'd0,1'b0,1'b0,1'b1,4'd11}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  cmp_sel = '0;
    logic        is_signed = 1'b0;
    logic        ext_mode = 1'b0;
    logic        carry_in = 1'b0;
    logic        zero_in = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        pred_in = 1'b0;
    logic        pred_inv = 1'b0;
    logic [1:0]  bool_sel = '0;
    logic        float_res = 1'b0;
    logic        flag_upd = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        zf_we;
    logic        zf_out;
    logic        err_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    icmpset_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .cmp_sel(cmp_sel),
        .is_signed(is_signed), .ext_mode(ext_mode), .carry_in(carry_in),
        .zero_in(zero_in), .op_a(op_a), .op_b(op_b), .pred_in(pred_in),
        .pred_inv(pred_inv), .bool_sel(bool_sel), .float_res(float_res),
        .flag_upd(flag_upd), .out_valid(out_valid), .out_word(out_word),
        .zf_we(zf_we), .zf_out(zf_out), .err_out(err_out)
    );

    task automatic drive(input vec_t v);
        cmp_sel = v.cmp; is_signed = v.sg; ext_mode = v.ext; carry_in = v.ci;
        zero_in = v.zi; op_a = v.a; op_b = v.b; pred_in = v.pr; pred_inv = v.pi;
        bool_sel = v.bop; float_res = v.fl; flag_upd = v.cc;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R12 reset dominates a live request
        drive(TBL[17]);
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 0 && out_word == 0 && zf_we == 0 && zf_out == 0 && err_out == 0,
              "R12", "reset state", {27'd0, out_valid, zf_we, zf_out, err_out, 1'b0} | out_word,
              32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            in_valid = 1'b1;
            @(negedge clk);
            check(out_valid && out_word == TBL[i].ew, $sformatf("R%0d", TBL[i].rq),
                  $sformatf("row %0d word", i), out_word, TBL[i].ew);
            check(zf_we == TBL[i].ewe && err_out == TBL[i].eer &&
                  (!TBL[i].ewe || zf_out == TBL[i].ezf),
                  $sformatf("R%0d", TBL[i].rq), $sformatf("row %0d we/zf/err", i),
                  {29'd0, zf_we, zf_out, err_out},
                  {29'd0, TBL[i].ewe, TBL[i].ezf, TBL[i].eer});
        end

        // R12 hold while idle: last word was zero; load a known nonzero first
        drive(TBL[17]);
        @(negedge clk);
        check(out_word == ONES, "R12", "load before idle", out_word, ONES);
        in_valid = 1'b0;
        drive(TBL[16]);
        @(negedge clk);
        check(out_valid == 1'b0, "R12", "valid drops", {31'd0, out_valid}, 32'd0);
        check(out_word == ONES, "R12", "word held while idle", out_word, ONES);
        @(negedge clk);
        check(out_word == ONES && zf_we == 0 && err_out == 0, "R12", "still held",
              out_word, ONES);

        // R10 zf_out keeps last written value when no flag update
        in_valid = 1'b1;
        drive(TBL[23]);
        @(negedge clk);
        drive(TBL[17]);
        @(negedge clk);
        check(zf_we == 0 && zf_out == 1'b1, "R10", "flag held without update",
              {30'd0, zf_we, zf_out}, 32'd1);
        in_valid = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule